// File: doc/BRIEF.md
# Non-volatile Array Program/Erase Strobe Sequencer

This block sits between a command source and a raw non-volatile memory array. It takes one of four commands: read, word program, page erase or mass erase. With the command it takes an address, a data word and a flag that picks the auxiliary (information) block instead of the main block. It then walks the array's enable and high-voltage strobes through an ordered list of phases. Each phase lasts a fixed number of system clock cycles. That number is derived at elaboration from a time in nanoseconds and the clock frequency parameter.

While a sequence runs, `busy` is high. At the end a one-cycle `done` pulse is given. A command that arrives while busy is refused with a one-cycle `err` pulse. A single down-counter times every phase, and the state machine advances only when that counter reaches zero. A synchronous reset silences the strobes at once and returns the block to standby.

Top module: `flash_seq`

## Requirements
- R1: Out of reset and whenever idle, all eight strobes, `busy`, `done` and `err` are low.
- R2: A command is accepted on a clock edge where `cmd_valid` is high and `busy` is low. `cmd_op` encodes 0 = read, 1 = word program, 2 = page erase, 3 = mass erase. A read holds `row_en`, `col_en`, `sense_en` and `dout_en` high for the read count. During a read, `prog_hv`, `erase_hv`, `mass_sel` and `store_en` stay low.
- R3: Word program produces these strobe phases in order:
  - `row_en` + `prog_hv` for the program-to-store setup count;
  - then `store_en` is added, for the store-to-program setup count;
  - then `col_en` is added, for the program pulse count;
  - then only `row_en` + `store_en`, for the store hold count;
  - then all strobes low, for the recovery count.
- R4: Page erase produces these strobe phases in order:
  - `row_en` + `erase_hv` for the setup count;
  - then `store_en` is added, for the erase count;
  - then `row_en` + `store_en`, for the store hold count;
  - then all strobes low, for the recovery count.
  `col_en`, `sense_en` and `dout_en` stay low throughout.
- R5: Mass erase follows the R4 sequence with `mass_sel` also high from the setup phase through the store hold phase. It uses the mass erase count (100 ms) and the long store hold count (100 us).
- R6: Every phase count equals ceil(time_ns × CLK_HZ / 1e9), with a floor of 1. Strobes change only when the running phase count expires.
- R7: After recovery, `done` pulses high for exactly one cycle with `busy` low. `busy` is high on every cycle from acceptance until then.
- R8: `info_sel` equals the accepted `cmd_info` and holds it for the whole operation.
- R9: Address and data are captured at acceptance and held on `arr_addr`/`arr_din` until the next accepted command. Page erase clears the low PAGE_W address bits. Mass erase drives an all-zero address.
- R10: `cmd_valid` while busy yields a one-cycle `err` on the following cycle. The refused command changes neither the address nor the running sequence.
- R11: While `rst` is high, all strobes are low in that same cycle. After the reset edge, `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | Operation code |
| cmd_addr | input | ADDR_W | Word address |
| cmd_data | input | DATA_W | Program data |
| cmd_info | input | 1 | Select information block |
| row_en | output | 1 | Row decoder enable |
| col_en | output | 1 | Column mux enable |
| sense_en | output | 1 | Sense amplifier enable |
| dout_en | output | 1 | Array data-out enable |
| prog_hv | output | 1 | Program high-voltage strobe |
| erase_hv | output | 1 | Erase high-voltage strobe |
| mass_sel | output | 1 | Whole-block erase select |
| store_en | output | 1 | Non-volatile store strobe |
| info_sel | output | 1 | Information block select to array |
| arr_addr | output | ADDR_W | Address to array |
| arr_din | output | DATA_W | Data to array |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle refused-command pulse |

## Verification
The first phase of a sequence appears in the cycle right after the accepting edge. Each later phase starts exactly its count of cycles after the one before it. `done` shows in the cycle after recovery ends. `err` follows the refused request by one cycle. Reset silences the strobes combinationally, in its own cycle.

The bench samples every cycle at the falling edge and compresses the strobe vector into runs of (pattern, length). It then compares the runs against a list that it computes itself, counting the cycle for each time by repeated comparison rather than by division. It also checks the `err` pulse and the reset behaviour at the exact falling edge where each is due.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [1:0] {
    OP_READ   = 2'd0,
    OP_PROG   = 2'd1,
    OP_PERASE = 2'd2,
    OP_MERASE = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_SETUP,
    ST_PGSET,
    ST_PULSE,
    ST_HOLD,
    ST_RECOV
  } state_e;

  typedef struct packed {
    logic row;
    logic col;
    logic sense;
    logic dout;
    logic prog;
    logic erase;
    logic mass;
    logic store;
  } strobe_t;

  // ceil(ns * hz / 1e9), never below one cycle
  function automatic longint unsigned ns_to_cycles(longint unsigned ns,
                                                   longint unsigned hz);
    longint unsigned c;
    c = (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
    return (c == 0) ? 64'd1 : c;
  endfunction

endpackage

// File: rtl/fseq_timer.sv
module fseq_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= '0;
    else if (load)        cnt_q <= load_val;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/fseq_cmd_reg.sv
module fseq_cmd_reg
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 16,
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  op_e               op_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] data_in,
  input  logic              info_in,
  output op_e               op_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] data_q,
  output logic              info_q
);
  localparam logic [ADDR_W-1:0] PAGE_MASK =
    {{(ADDR_W-PAGE_W){1'b1}}, {PAGE_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q   <= OP_READ;
      addr_q <= '0;
      data_q <= '0;
      info_q <= 1'b0;
    end else if (capture) begin
      op_q   <= op_in;
      data_q <= data_in;
      info_q <= info_in;
      case (op_in)
        OP_PERASE: addr_q <= addr_in & PAGE_MASK;
        OP_MERASE: addr_q <= '0;
        default:   addr_q <= addr_in;
      endcase
    end
  end
endmodule

// File: rtl/fseq_strobe_dec.sv
module fseq_strobe_dec
  import flash_seq_pkg::*;
(
  input  state_e  state,
  input  op_e     op,
  input  logic    rst,
  output strobe_t strb
);
  logic is_prog, is_mass;
  assign is_prog = (op == OP_PROG);
  assign is_mass = (op == OP_MERASE);

  always_comb begin
    strb = '0;
    case (state)
      ST_READ: begin
        strb.row = 1'b1; strb.col = 1'b1; strb.sense = 1'b1; strb.dout = 1'b1;
      end
      ST_SETUP: begin
        strb.row = 1'b1; strb.prog = is_prog; strb.erase = !is_prog;
        strb.mass = is_mass;
      end
      ST_PGSET: begin
        strb.row = 1'b1; strb.prog = 1'b1; strb.store = 1'b1;
      end
      ST_PULSE: begin
        strb.row = 1'b1; strb.store = 1'b1; strb.col = is_prog;
        strb.prog = is_prog; strb.erase = !is_prog; strb.mass = is_mass;
      end
      ST_HOLD: begin
        strb.row = 1'b1; strb.store = 1'b1; strb.mass = is_mass;
      end
      default: strb = '0;
    endcase
    if (rst) strb = '0;
  end
endmodule

// File: rtl/flash_seq.sv
module flash_seq
  import flash_seq_pkg::*;
#(
  parameter int          ADDR_W     = 13,
  parameter int          DATA_W     = 16,
  parameter int          PAGE_W     = 8,
  parameter longint      CLK_HZ     = 80_000_000,
  parameter longint      T_READ_NS  = 50,
  parameter longint      T_SETUP_NS = 5_000,
  parameter longint      T_PGSET_NS = 10_000,
  parameter longint      T_PROG_NS  = 20_000,
  parameter longint      T_HOLD_NS  = 5_000,
  parameter longint      T_HOLDM_NS = 100_000,
  parameter longint      T_ERASE_NS = 20_000_000,
  parameter longint      T_MASS_NS  = 100_000_000,
  parameter longint      T_RECOV_NS = 1_000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              cmd_info,
  output logic              row_en,
  output logic              col_en,
  output logic              sense_en,
  output logic              dout_en,
  output logic              prog_hv,
  output logic              erase_hv,
  output logic              mass_sel,
  output logic              store_en,
  output logic              info_sel,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_din,
  output logic              busy,
  output logic              done,
  output logic              err
);
  localparam longint C_READ  = ns_to_cycles(T_READ_NS,  CLK_HZ);
  localparam longint C_SETUP = ns_to_cycles(T_SETUP_NS, CLK_HZ);
  localparam longint C_PGSET = ns_to_cycles(T_PGSET_NS, CLK_HZ);
  localparam longint C_PROG  = ns_to_cycles(T_PROG_NS,  CLK_HZ);
  localparam longint C_HOLD  = ns_to_cycles(T_HOLD_NS,  CLK_HZ);
  localparam longint C_HOLDM = ns_to_cycles(T_HOLDM_NS, CLK_HZ);
  localparam longint C_ERASE = ns_to_cycles(T_ERASE_NS, CLK_HZ);
  localparam longint C_MASS  = ns_to_cycles(T_MASS_NS,  CLK_HZ);
  localparam longint C_RECOV = ns_to_cycles(T_RECOV_NS, CLK_HZ);
  localparam longint C_M1 = (C_MASS  > C_ERASE) ? C_MASS  : C_ERASE;
  localparam longint C_M2 = (C_HOLDM > C_PROG)  ? C_HOLDM : C_PROG;
  localparam longint C_MAX = (C_M1 > C_M2) ? C_M1 : C_M2;
  localparam int CW = $clog2(C_MAX + 1);

  state_e           state_q, state_d;
  op_e              op_q;
  logic             info_q;
  logic             accept, load;
  logic             phase_end;   // running phase count has expired
  logic [CW-1:0]    load_val;
  logic             done_q, err_q;
  strobe_t          strb;

  assign accept = cmd_valid && (state_q == ST_IDLE) && !rst;

  fseq_cmd_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_cmd (
    .clk(clk), .rst(rst), .capture(accept),
    .op_in(op_e'(cmd_op)), .addr_in(cmd_addr), .data_in(cmd_data),
    .info_in(cmd_info),
    .op_q(op_q), .addr_q(arr_addr), .data_q(arr_din), .info_q(info_q)
  );

  fseq_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst(rst), .load(load), .load_val(load_val),
    .expired(phase_end)
  );

  always_comb begin
    state_d  = state_q;
    load     = 1'b0;
    load_val = '0;
    case (state_q)
      ST_IDLE: if (accept) begin
        load = 1'b1;
        if (op_e'(cmd_op) == OP_READ) begin
          state_d = ST_READ;  load_val = CW'(C_READ - 1);
        end else begin
          state_d = ST_SETUP; load_val = CW'(C_SETUP - 1);
        end
      end
      ST_READ: if (phase_end) state_d = ST_IDLE;
      ST_SETUP: if (phase_end) begin
        load = 1'b1;
        if (op_q == OP_PROG) begin
          state_d = ST_PGSET; load_val = CW'(C_PGSET - 1);
        end else begin
          state_d  = ST_PULSE;
          load_val = (op_q == OP_MERASE) ? CW'(C_MASS - 1) : CW'(C_ERASE - 1);
        end
      end
      ST_PGSET: if (phase_end) begin
        load = 1'b1; state_d = ST_PULSE; load_val = CW'(C_PROG - 1);
      end
      ST_PULSE: if (phase_end) begin
        load = 1'b1; state_d = ST_HOLD;
        load_val = (op_q == OP_MERASE) ? CW'(C_HOLDM - 1) : CW'(C_HOLD - 1);
      end
      ST_HOLD: if (phase_end) begin
        load = 1'b1; state_d = ST_RECOV; load_val = CW'(C_RECOV - 1);
      end
      ST_RECOV: if (phase_end) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= phase_end && (state_q == ST_READ || state_q == ST_RECOV);
      err_q   <= cmd_valid && (state_q != ST_IDLE);
    end
  end

  fseq_strobe_dec u_dec (.state(state_q), .op(op_q), .rst(rst), .strb(strb));

  assign row_en   = strb.row;
  assign col_en   = strb.col;
  assign sense_en = strb.sense;
  assign dout_en  = strb.dout;
  assign prog_hv  = strb.prog;
  assign erase_hv = strb.erase;
  assign mass_sel = strb.mass;
  assign store_en = strb.store;
  assign info_sel = info_q;
  assign busy     = (state_q != ST_IDLE);
  assign done     = done_q;
  assign err      = err_q;
endmodule

// File: rtl/flash_seq_chk.sv
module flash_seq_chk #(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic              row_en,
  input logic              col_en,
  input logic              sense_en,
  input logic              dout_en,
  input logic              prog_hv,
  input logic              erase_hv,
  input logic              mass_sel,
  input logic              store_en,
  input logic              info_sel,
  input logic [ADDR_W-1:0] arr_addr,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic              phase_end
);
  logic [7:0] strb;
  assign strb = {row_en, col_en, sense_en, dout_en, prog_hv, erase_hv, mass_sel, store_en};

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> strb == 8'h00);  // R1
  AST_READ_NO_HV: assert property (@(posedge clk) disable iff (rst)
    sense_en |-> !(prog_hv || erase_hv || mass_sel || store_en));  // R2
  AST_STORE_AFTER_SETUP: assert property (@(posedge clk) disable iff (rst)
    $rose(store_en) |-> $past(prog_hv || erase_hv));  // R3
  AST_COL_IN_STORE: assert property (@(posedge clk) disable iff (rst)
    (col_en && prog_hv) |-> store_en);  // R3
  AST_HV_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(prog_hv && erase_hv));  // R4
  AST_MASS_WITH_ERASE: assert property (@(posedge clk) disable iff (rst)
    $rose(mass_sel) |-> erase_hv);  // R5
  AST_PHASE_STABLE: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !$past(phase_end)) |-> $stable(strb));  // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy ##1 !done));  // R7
  AST_INFO_HELD: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(info_sel));  // R8
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(arr_addr));  // R9
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
    err |-> $past(busy && cmd_valid));  // R10
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |-> strb == 8'h00);  // R11
endmodule

bind flash_seq flash_seq_chk #(.ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/flash_seq_tb_top.sv
module flash_seq_tb_top;
  localparam longint HZ = 200_000;
  localparam int AW = 13;
  localparam int DW = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst = 1'b1, cmd_valid = 1'b0, cmd_info = 1'b0;
  logic [1:0] cmd_op = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_data = '0;
  logic row_en, col_en, sense_en, dout_en, prog_hv, erase_hv, mass_sel, store_en;
  logic info_sel, busy, done, err;
  logic [AW-1:0] arr_addr;
  logic [DW-1:0] arr_din;

  flash_seq #(.ADDR_W(AW), .DATA_W(DW), .CLK_HZ(HZ)) dut_i (.*);

  logic [7:0] vec;
  assign vec = {row_en, col_en, sense_en, dout_en, prog_hv, erase_hv, mass_sel, store_en};

  int n_tests = 0, n_fail = 0;
  logic [7:0] rv[8];  int rl[8];  int nr;
  logic [7:0] ev[8];  int el[8];  int ne;
  bit hold_ok, busy_ok;

  // cycles needed for ns at HZ, found by counting upward
  function automatic int cyc(longint ns);
    int n = 0;
    while (longint'(n) * 64'd1_000_000_000 < ns * HZ) n++;
    return (n < 1) ? 1 : n;
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic issue(logic [1:0] op, logic [AW-1:0] a, logic [DW-1:0] d, logic inf);
    @(posedge clk); #1;
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d; cmd_info = inf;
    @(posedge clk); #1;
    cmd_valid = 1'b0;
  endtask

  // issue a command and log strobe runs until done
  task automatic run_op(logic [1:0] op, logic [AW-1:0] a, logic [DW-1:0] d, logic inf,
                        logic [AW-1:0] xa);
    nr = 0; hold_ok = 1; busy_ok = 1;
    issue(op, a, d, inf);
    for (int i = 0; i < 30000; i++) begin
      @(negedge clk);
      if (done) break;
      if (!busy) busy_ok = 0;
      if (arr_addr !== xa || info_sel !== inf || (op == 2'd1 && arr_din !== d)) hold_ok = 0;
      if (nr > 0 && rv[nr-1] == vec) rl[nr-1]++;
      else if (nr < 8) begin rv[nr] = vec; rl[nr] = 1; nr++; end
    end
  endtask

  task automatic cmp_runs(string req);
    check(nr == ne, req, "phase count", nr, ne);
    for (int i = 0; i < ne && i < nr; i++) begin
      check(rv[i] == ev[i], req, $sformatf("phase %0d strobes", i), rv[i], ev[i]);
      check(rl[i] == el[i], req, $sformatf("phase %0d length", i), rl[i], el[i]);
    end
    check(busy_ok, "R7", "busy during op", busy_ok, 1);
    check(done && !busy, "R7", "done pulse with busy low", {done, busy}, 2'b10);
    @(negedge clk);
    check(!done, "R7", "done lasts one cycle", done, 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(vec == 8'h00 && !busy && !done && !err, "R1", "idle outputs",
          {vec, busy, done, err}, 0);
  endtask

  task automatic t_read;
    run_op(2'd0, 13'h0042, 16'h0, 1'b1, 13'h0042);
    ne = 1; ev[0] = 8'hF0; el[0] = cyc(50);
    cmp_runs("R2");
    check(hold_ok, "R8", "read info/addr held", hold_ok, 1);
  endtask

  task automatic t_program;
    run_op(2'd1, 13'h0123, 16'hBEEF, 1'b0, 13'h0123);
    ne = 5;
    ev[0] = 8'h88; el[0] = cyc(5_000);
    ev[1] = 8'h89; el[1] = cyc(10_000);
    ev[2] = 8'hC9; el[2] = cyc(20_000);
    ev[3] = 8'h81; el[3] = cyc(5_000);
    ev[4] = 8'h00; el[4] = cyc(1_000);
    cmp_runs("R3");
    check(hold_ok, "R9", "program addr/data held", hold_ok, 1);
    check(el[1] == 2 && el[2] == 4, "R6", "ceil counts", el[2], 4);
  endtask

  task automatic t_page;
    run_op(2'd2, 13'h0A5B, 16'h0, 1'b0, 13'h0A00);
    ne = 4;
    ev[0] = 8'h84; el[0] = cyc(5_000);
    ev[1] = 8'h85; el[1] = cyc(20_000_000);
    ev[2] = 8'h81; el[2] = cyc(5_000);
    ev[3] = 8'h00; el[3] = cyc(1_000);
    cmp_runs("R4");
    check(hold_ok, "R9", "page address masked and held", arr_addr, 13'h0A00);
  endtask

  task automatic t_mass;
    run_op(2'd3, 13'h1234, 16'h0, 1'b1, 13'h0000);
    ne = 4;
    ev[0] = 8'h86; el[0] = cyc(5_000);
    ev[1] = 8'h87; el[1] = cyc(100_000_000);
    ev[2] = 8'h83; el[2] = cyc(100_000);
    ev[3] = 8'h00; el[3] = cyc(1_000);
    cmp_runs("R5");
    check(hold_ok, "R8", "mass info_sel held, addr zero", info_sel, 1);
  endtask

  task automatic t_reject;
    int bc;
    issue(2'd2, 13'h0345, 16'h0, 1'b0);
    bc = 0;
    for (int i = 0; i < 3; i++) begin @(negedge clk); if (busy) bc++; end
    cmd_valid = 1'b1; cmd_op = 2'd1; cmd_addr = 13'h1FFF; cmd_info = 1'b1;
    @(negedge clk); if (busy) bc++;
    cmd_valid = 1'b0;
    check(err == 1'b1, "R10", "err after refused command", err, 1);
    check(arr_addr == 13'h0300 && !info_sel, "R10", "refused addr ignored", arr_addr, 13'h0300);
    check(vec == 8'h85, "R10", "sequence unaffected", vec, 8'h85);
    @(negedge clk); if (busy) bc++;
    check(err == 1'b0, "R10", "err one cycle", err, 0);
    for (int i = 0; i < 30000; i++) begin
      if (done) break;
      @(negedge clk); if (busy) bc++;
    end
    check(bc == cyc(5_000) + cyc(20_000_000) + cyc(5_000) + cyc(1_000), "R10",
          "busy length after refusal", bc, 4003);
  endtask

  task automatic t_sync_reset;
    issue(2'd2, 13'h0100, 16'h0, 1'b0);
    for (int i = 0; i < 5; i++) @(negedge clk);
    rst = 1'b1; #1;
    check(vec == 8'h00, "R11", "strobes low in reset cycle", vec, 0);
    @(negedge clk);
    check(!busy && vec == 8'h00, "R11", "idle after reset edge", busy, 0);
    rst = 1'b0;
    run_op(2'd0, 13'h0007, 16'h0, 1'b0, 13'h0007);
    ne = 1; ev[0] = 8'hF0; el[0] = cyc(50);
    cmp_runs("R11");
  endtask

  task automatic finish_run;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_read();
    t_program();
    t_page();
    t_mass();
    t_reject();
    t_sync_reset();
    finish_run();
  end

  initial begin
    #(20 * 190_000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule